// File: doc/BRIEF.md
# Keyboard Scan-Code Hex Letter Filter

This block sits behind two independent keyboard-protocol byte receivers, one on the keyboard port and one on the mouse port. Every byte a receiver hands over is turned into one display character. Only the six scan codes of the letter keys A to F become their letters. Any other byte becomes a question mark, and that includes release prefixes, extended prefixes, typematic repeats and bytes the receiver flags as damaged.

Each port keeps the last character it produced. It shows that character on a character output and on a three-character status field: a port tag, a colon, then the character. A one-cycle update pulse marks every new value, so a display driver or logger downstream can see each received byte, even when the character does not change.

Top module: `hex_key_filter`

## Requirements
- R1: After reset both held characters are '?' (0x3F), both update pulses are low, and the fields read "K:?" and "M:?".
- R2: A valid byte with no error flag is mapped as follows: 0x1C gives 'A' (0x41), 0x32 gives 'B', 0x21 gives 'C', 0x23 gives 'D', 0x24 gives 'E' and 0x2B gives 'F' (0x46).
- R3: Any other valid byte overwrites the held character with '?' (0x3F). This includes the release prefix 0xF0, the extended prefix 0xE0, 0x00 and 0xFF.
- R4: A valid byte whose error flag is high yields '?', even when the byte is a letter code.
- R5: The held character takes its new value in the cycle after the one in which the valid strobe is sampled high. In that same cycle the port's update pulse is high. The pulse is high for exactly one cycle per valid byte, and strobes in back-to-back cycles give pulses in back-to-back cycles.
- R6: While a port's valid strobe is low, changes on its byte and error inputs have no effect. The held character, the field and the update pulse stay as they are, and the pulse stays low.
- R7: The two ports are independent. A byte on one port leaves the other port's character and pulse unchanged.
- R8: Each field is {tag, ':' (0x3A), held character}, with the tag in bits 23:16 and the character in bits 7:0. The keyboard tag is 'K' (0x4B) and the mouse tag is 'M' (0x4D).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| kbdByte | input | 8 | Received byte, keyboard port |
| kbdValid | input | 1 | Keyboard byte strobe, one cycle per byte |
| kbdErr | input | 1 | Keyboard receiver parity or framing error for this byte |
| mseByte | input | 8 | Received byte, mouse port |
| mseValid | input | 1 | Mouse byte strobe, one cycle per byte |
| mseErr | input | 1 | Mouse receiver parity or framing error for this byte |
| kbdChar | output | 8 | Last keyboard character, ASCII |
| kbdUpdate | output | 1 | One-cycle pulse when kbdChar is rewritten |
| kbdField | output | 24 | Keyboard status field "K:x" |
| mseChar | output | 8 | Last mouse character, ASCII |
| mseUpdate | output | 1 | One-cycle pulse when mseChar is rewritten |
| mseField | output | 24 | Mouse status field "M:x" |

## Verification
The assertions take two things for granted about the inputs. Each valid strobe stands for exactly one byte. Byte and error inputs only count in the cycle where that strobe is high, and may hold any value outside those cycles. The bench drives all inputs on the falling edge and holds each strobe for a single rising edge, except in the deliberate back-to-back case. Between strobes it moves the byte and error lines to letter codes, so the check that idle inputs have no effect would fail if they leaked through.

// File: rtl/hkf_pkg.sv
package hkf_pkg;

  localparam int CODE_W = 8;
  localparam int CHAR_W = 8;
  localparam logic [CHAR_W-1:0] UNKNOWN_CHAR = 8'h3F;
  localparam logic [CHAR_W-1:0] COLON_CHAR   = 8'h3A;

  // Strobes from control to datapath, one set per port
  typedef struct packed {
    logic capture;       // load the held character this edge
    logic forceUnknown;  // receiver flagged the byte as damaged
  } portStrobe_t;

  // Scan code to ASCII; only the six hex letter keys are recognized
  function automatic logic [CHAR_W-1:0] mapCode(input logic [CODE_W-1:0] code);
    logic [CHAR_W-1:0] ch;
    case (code)
      8'h1C:   ch = 8'h41;
      8'h32:   ch = 8'h42;
      8'h21:   ch = 8'h43;
      8'h23:   ch = 8'h44;
      8'h24:   ch = 8'h45;
      8'h2B:   ch = 8'h46;
      default: ch = UNKNOWN_CHAR;
    endcase
    return ch;
  endfunction

endpackage

// File: rtl/hkf_ctrl.sv
module hkf_ctrl
  import hkf_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic        [NUM_PORTS-1:0]       byteValid,
  input  logic        [NUM_PORTS-1:0]       byteErr,
  output portStrobe_t [NUM_PORTS-1:0]       strb,
  output logic        [NUM_PORTS-1:0]       updatePulse
);

  logic [NUM_PORTS-1:0] pulseQ;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      strb[p].capture      = byteValid[p];
      strb[p].forceUnknown = byteErr[p];
    end

    always_ff @(posedge clk) begin
      if (!rstN) pulseQ[p] <= 1'b0;
      else       pulseQ[p] <= byteValid[p];
    end
  end

  assign updatePulse = pulseQ;

endmodule

// File: rtl/hkf_datapath.sv
module hkf_datapath
  import hkf_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic        [NUM_PORTS-1:0][CODE_W-1:0] codeIn,
  input  portStrobe_t [NUM_PORTS-1:0]        strb,
  output logic        [NUM_PORTS-1:0][CHAR_W-1:0] heldChar
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [CHAR_W-1:0] nextChar;
    logic [CHAR_W-1:0] charQ;

    always_comb begin
      if (strb[p].forceUnknown) nextChar = UNKNOWN_CHAR;
      else                      nextChar = mapCode(codeIn[p]);
    end

    always_ff @(posedge clk) begin
      if (!rstN)                charQ <= UNKNOWN_CHAR;
      else if (strb[p].capture) charQ <= nextChar;
    end

    assign heldChar[p] = charQ;
  end

endmodule

// File: rtl/hex_key_filter.sv
module hex_key_filter
  import hkf_pkg::*;
#(
  parameter logic [CHAR_W-1:0] KBD_TAG = 8'h4B,
  parameter logic [CHAR_W-1:0] MSE_TAG = 8'h4D
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CODE_W-1:0]    kbdByte,
  input  logic                 kbdValid,
  input  logic                 kbdErr,
  input  logic [CODE_W-1:0]    mseByte,
  input  logic                 mseValid,
  input  logic                 mseErr,
  output logic [CHAR_W-1:0]    kbdChar,
  output logic                 kbdUpdate,
  output logic [3*CHAR_W-1:0]  kbdField,
  output logic [CHAR_W-1:0]    mseChar,
  output logic                 mseUpdate,
  output logic [3*CHAR_W-1:0]  mseField
);

  localparam int NUM_PORTS = 2;
  localparam int KBD = 0;
  localparam int MSE = 1;

  portStrobe_t [NUM_PORTS-1:0]             strb;
  logic        [NUM_PORTS-1:0]             upd;
  logic        [NUM_PORTS-1:0][CHAR_W-1:0] held;

  hkf_ctrl #(.NUM_PORTS(NUM_PORTS)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  ({mseValid, kbdValid}),
    .byteErr    ({mseErr, kbdErr}),
    .strb       (strb),
    .updatePulse(upd)
  );

  hkf_datapath #(.NUM_PORTS(NUM_PORTS)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .codeIn  ({mseByte, kbdByte}),
    .strb    (strb),
    .heldChar(held)
  );

  assign kbdChar   = held[KBD];
  assign mseChar   = held[MSE];
  assign kbdUpdate = upd[KBD];
  assign mseUpdate = upd[MSE];
  assign kbdField  = {KBD_TAG, COLON_CHAR, held[KBD]};
  assign mseField  = {MSE_TAG, COLON_CHAR, held[MSE]};

endmodule

// File: rtl/hkf_checker.sv
module hkf_checker (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  code,
  input logic        valid,
  input logic        err,
  input logic [7:0]  ch,
  input logic        upd,
  input logic [23:0] field,
  input logic        otherValid,
  input logic [7:0]  tagExp
);

  // R5: a sampled strobe is followed by an update pulse
  a_r5_pulse_after_valid: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> upd);

  // R6: no strobe, no pulse and no change of the held character
  a_r6_idle_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> !upd);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> $stable(ch));

  // R4: a flagged byte always yields the unknown character
  a_r4_err_unknown: assert property (@(posedge clk) disable iff (!rstN)
    (valid && err) |=> (ch == 8'h3F));

  // R2: letter A and letter F codes
  a_r2_letter_a: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !err && code == 8'h1C) |=> (ch == 8'h41));
  a_r2_letter_f: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !err && code == 8'h2B) |=> (ch == 8'h46));

  // R3: release prefix gives the unknown character
  a_r3_release_unknown: assert property (@(posedge clk) disable iff (!rstN)
    (valid && code == 8'hF0) |=> (ch == 8'h3F));

  // R7: a strobe on the other port alone leaves this port alone
  a_r7_isolated: assert property (@(posedge clk) disable iff (!rstN)
    (otherValid && !valid) |=> (!upd && $stable(ch)));

  // R8: field layout
  a_r8_field: assert property (@(posedge clk) disable iff (!rstN)
    (field[23:16] == tagExp) && (field[15:8] == 8'h3A) && (field[7:0] == ch));

endmodule

bind hex_key_filter hkf_checker kbd_chk_i (
  .clk(clk), .rstN(rstN), .code(kbdByte), .valid(kbdValid), .err(kbdErr),
  .ch(kbdChar), .upd(kbdUpdate), .field(kbdField), .otherValid(mseValid),
  .tagExp(8'h4B)
);

bind hex_key_filter hkf_checker mse_chk_i (
  .clk(clk), .rstN(rstN), .code(mseByte), .valid(mseValid), .err(mseErr),
  .ch(mseChar), .upd(mseUpdate), .field(mseField), .otherValid(kbdValid),
  .tagExp(8'h4D)
);

// File: tb/hex_key_filter_tb_top.sv
module hex_key_filter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  kbdByte = 8'h00, mseByte = 8'h00;
  logic        kbdValid = 1'b0, mseValid = 1'b0;
  logic        kbdErr = 1'b0, mseErr = 1'b0;
  logic [7:0]  kbdChar, mseChar;
  logic        kbdUpdate, mseUpdate;
  logic [23:0] kbdField, mseField;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hex_key_filter dut_i (
    .clk(clk), .rstN(rstN),
    .kbdByte(kbdByte), .kbdValid(kbdValid), .kbdErr(kbdErr),
    .mseByte(mseByte), .mseValid(mseValid), .mseErr(mseErr),
    .kbdChar(kbdChar), .kbdUpdate(kbdUpdate), .kbdField(kbdField),
    .mseChar(mseChar), .mseUpdate(mseUpdate), .mseField(mseField)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] refMap(input logic [7:0] c, input logic e);
    if (e) return 8'h3F;
    case (c)
      8'h1C: return 8'h41;
      8'h32: return 8'h42;
      8'h21: return 8'h43;
      8'h23: return 8'h44;
      8'h24: return 8'h45;
      8'h2B: return 8'h46;
      default: return 8'h3F;
    endcase
  endfunction

  // Drive one byte on a port (0 keyboard, 1 mouse); called at a falling edge
  task automatic sendByte(input int port, input logic [7:0] c, input logic e, input string req);
    logic [7:0] exp;
    logic [7:0] otherBefore;
    exp = refMap(c, e);
    otherBefore = (port == 0) ? mseChar : kbdChar;
    if (port == 0) begin kbdByte = c; kbdErr = e; kbdValid = 1'b1; end
    else           begin mseByte = c; mseErr = e; mseValid = 1'b1; end
    @(negedge clk);
    kbdValid = 1'b0; mseValid = 1'b0;
    if (port == 0) begin
      check({req, " kbd char"}, kbdChar, exp);
      check("R5 kbd pulse", kbdUpdate, 1);
      check("R8 kbd field", kbdField, {8'h4B, 8'h3A, exp});
      check("R7 mse untouched", {mseUpdate, mseChar}, {1'b0, otherBefore});
    end else begin
      check({req, " mse char"}, mseChar, exp);
      check("R5 mse pulse", mseUpdate, 1);
      check("R8 mse field", mseField, {8'h4D, 8'h3A, exp});
      check("R7 kbd untouched", {kbdUpdate, kbdChar}, {1'b0, otherBefore});
    end
    @(negedge clk);
    check("R5 pulse one cycle", {kbdUpdate, mseUpdate}, 0);
  endtask

  task automatic testReset();
    check("R1 kbd char", kbdChar, 8'h3F);
    check("R1 mse char", mseChar, 8'h3F);
    check("R1 pulses", {kbdUpdate, mseUpdate}, 0);
    check("R1 kbd field", kbdField, 24'h4B3A3F);
    check("R1 mse field", mseField, 24'h4D3A3F);
  endtask

  task automatic testLetters();
    logic [7:0] codes [6] = '{8'h1C, 8'h32, 8'h21, 8'h23, 8'h24, 8'h2B};
    for (int i = 0; i < 6; i++) sendByte(0, codes[i], 1'b0, "R2");
    for (int i = 5; i >= 0; i--) sendByte(1, codes[i], 1'b0, "R2");
  endtask

  task automatic testUnknown();
    sendByte(0, 8'h24, 1'b0, "R2");
    sendByte(0, 8'hF0, 1'b0, "R3 release");
    sendByte(0, 8'h1C, 1'b0, "R2");
    sendByte(0, 8'hE0, 1'b0, "R3 extended");
    sendByte(1, 8'h23, 1'b0, "R2");
    sendByte(1, 8'h00, 1'b0, "R3 zero");
    sendByte(1, 8'h32, 1'b0, "R2");
    sendByte(1, 8'hFF, 1'b0, "R3 ones");
    sendByte(0, 8'h1D, 1'b0, "R3 neighbour");
  endtask

  task automatic testErr();
    sendByte(0, 8'h21, 1'b0, "R2");
    sendByte(0, 8'h21, 1'b1, "R4 kbd flagged");
    sendByte(1, 8'h2B, 1'b0, "R2");
    sendByte(1, 8'h2B, 1'b1, "R4 mse flagged");
  endtask

  task automatic testIdle();
    sendByte(0, 8'h32, 1'b0, "R2");
    sendByte(1, 8'h24, 1'b0, "R2");
    kbdByte = 8'h1C; kbdErr = 1'b1; mseByte = 8'hF0; mseErr = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R6 kbd hold", {kbdUpdate, kbdChar}, {1'b0, 8'h42});
      check("R6 mse hold", {mseUpdate, mseChar}, {1'b0, 8'h45});
      kbdByte = kbdByte + 8'h1; mseByte = mseByte - 8'h1;
    end
    kbdErr = 1'b0; mseErr = 1'b0;
  endtask

  task automatic testBackToBack();
    kbdByte = 8'h23; kbdValid = 1'b1;
    @(negedge clk);
    check("R5 b2b first char", kbdChar, 8'h44);
    check("R5 b2b first pulse", kbdUpdate, 1);
    kbdByte = 8'hF0;
    @(negedge clk);
    kbdValid = 1'b0;
    check("R5 b2b second char", kbdChar, 8'h3F);
    check("R5 b2b second pulse", kbdUpdate, 1);
    @(negedge clk);
    check("R5 b2b pulse ends", kbdUpdate, 0);
  endtask

  task automatic testBoth();
    kbdByte = 8'h2B; kbdValid = 1'b1; mseByte = 8'h1C; mseValid = 1'b1;
    @(negedge clk);
    kbdValid = 1'b0; mseValid = 1'b0;
    check("R7 both kbd", kbdChar, 8'h46);
    check("R7 both mse", mseChar, 8'h41);
    check("R7 both pulses", {kbdUpdate, mseUpdate}, 2'b11);
    @(negedge clk);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLetters();
    testUnknown();
    testErr();
    testIdle();
    testBackToBack();
    testBoth();
    finished = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

endmodule